// File: doc/BRIEF.md
# Raised-Cosine Soft Mute Ramp

This block sits in a stereo playback path and scales each incoming left/right sample pair by a shared gain. When mute is requested, the gain falls to zero in small steps along a raised-cosine curve, so the output fades without an audible click. When mute is released, the gain climbs back to full scale along the same curve. The gain is also forced toward zero while the sample-clock PLL reports loss of lock. The fade back up starts only once lock returns.

The gain has 33 positions. Position 0 is unity, positions 1 to 31 are fractional coefficients, and position 32 is silence. The position moves by at most one step per `HOLD_LEN` accepted samples, and it moves only when a sample strobe arrives. Every sample is therefore scaled by exactly one coefficient. A status output reports when the fade has reached silence.

Top module: `soft_mute_ramp`

## Requirements
- R1: After synchronous reset the block is at full mute. `fully_muted` is 1, `out_valid` is 0, and both output samples are 0.
- R2: A result appears on `out_left`/`out_right` with `out_valid` high for exactly one cycle, two clock edges after the edge that accepted `smp_valid`. `out_valid` is never high otherwise.
- R3: At gain position 0 (full scale), each output sample equals its input sample bit for bit.
- R4: At gain position 32 (silence), both output samples are exactly 0.
- R5: While the effective mute is active, the position rises from k toward 32 by one step after every `HOLD_LEN` (default 32) accepted samples. Positions k = 1..31 scale by round(65536·0.5·(1+cos(πk/32)))/65536. One full fade therefore lasts 32·`HOLD_LEN` samples, which is 1024 by default.
- R6: While the effective mute is inactive, the position falls toward 0 by one step after every `HOLD_LEN` accepted samples. The coefficients are therefore passed in reverse order.
- R7: If the effective mute changes in the middle of a ramp, the position reverses from its current value. The count of samples already spent at that position is kept, not cleared.
- R8: The effective mute is `mute_req` OR NOT `pll_locked`. With `pll_locked` low the block fades to and stays at silence whatever `mute_req` is.
- R9: Both channels use the same coefficient in the same sample. The product is rounded to nearest, with halves rounded up, and then saturated to the signed sample width.
- R10: The gain position changes only on a cycle with `smp_valid` high.
- R11: `fully_muted` is 1 exactly when the gain position is 32, and is updated on the edge that accepts the sample causing the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One-cycle strobe marking a new stereo sample |
| smp_left | input | DATA_W | Left input sample, two's complement |
| smp_right | input | DATA_W | Right input sample, two's complement |
| mute_req | input | 1 | Mute request (1 = mute) |
| pll_locked | input | 1 | Sample-clock PLL lock indication (1 = locked) |
| out_valid | output | 1 | Strobe marking a scaled sample pair |
| out_left | output | DATA_W | Scaled left sample |
| out_right | output | DATA_W | Scaled right sample |
| fully_muted | output | 1 | Gain has reached silence |

## Verification
The assertions check on every cycle that:
- the gain position never moves without a strobe;
- the position moves only in the direction the effective mute selects, and by at most one step;
- the full-mute flag tracks the position;
- unity and silence positions pass or clear the sample exactly;
- results emerge with a fixed two-edge latency.

The bench scenarios show what no single-cycle property can:
- the 32-sample dwell per coefficient;
- the cosine values themselves;
- mid-ramp reversal that keeps the dwell count;
- fade-in timing after PLL lock returns;
- rounding behaviour on full-scale positive and negative samples.

// File: rtl/smr_pkg.sv
package smr_pkg;

  localparam int STEPS  = 32;
  localparam int IDX_W  = 6;
  localparam int COEF_W = 16;

  // 65536 * 0.5 * (1 + cos(pi*k/32)), k = 1..31; k = 0 is handled as unity
  function automatic logic [COEF_W-1:0] ramp_coef(input logic [4:0] k);
    logic [COEF_W-1:0] c;
    case (k)
      5'd0:  c = 16'hFFFF;
      5'd1:  c = 16'd65378;
      5'd2:  c = 16'd64906;
      5'd3:  c = 16'd64125;
      5'd4:  c = 16'd63042;
      5'd5:  c = 16'd61667;
      5'd6:  c = 16'd60014;
      5'd7:  c = 16'd58098;
      5'd8:  c = 16'd55938;
      5'd9:  c = 16'd53556;
      5'd10: c = 16'd50973;
      5'd11: c = 16'd48215;
      5'd12: c = 16'd45308;
      5'd13: c = 16'd42280;
      5'd14: c = 16'd39161;
      5'd15: c = 16'd35980;
      5'd16: c = 16'd32768;
      5'd17: c = 16'd29556;
      5'd18: c = 16'd26375;
      5'd19: c = 16'd23256;
      5'd20: c = 16'd20228;
      5'd21: c = 16'd17321;
      5'd22: c = 16'd14563;
      5'd23: c = 16'd11980;
      5'd24: c = 16'd9598;
      5'd25: c = 16'd7438;
      5'd26: c = 16'd5522;
      5'd27: c = 16'd3869;
      5'd28: c = 16'd2494;
      5'd29: c = 16'd1411;
      5'd30: c = 16'd630;
      default: c = 16'd158;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/smr_ramp_ctrl.sv
module smr_ramp_ctrl
  import smr_pkg::*;
#(
  parameter int HOLD_LEN = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic             mute_req,
  input  logic             pll_locked,
  output logic [IDX_W-1:0] idx,
  output logic             fully_muted
);

  localparam int HOLD_W = (HOLD_LEN > 1) ? $clog2(HOLD_LEN) : 1;
  localparam logic [IDX_W-1:0]  IDX_END  = IDX_W'(STEPS);
  localparam logic [HOLD_W-1:0] HOLD_TOP = HOLD_W'(HOLD_LEN - 1);

  logic [HOLD_W-1:0] hold_q, hold_nxt;
  logic [IDX_W-1:0]  idx_nxt;
  logic              eff_mute, moving;

  always_comb begin
    eff_mute = mute_req | ~pll_locked;
    moving   = eff_mute ? (idx != IDX_END) : (idx != '0);
    idx_nxt  = idx;
    hold_nxt = hold_q;
    if (step_en && moving) begin
      if (hold_q == HOLD_TOP) begin
        hold_nxt = '0;
        idx_nxt  = eff_mute ? idx + 1'b1 : idx - 1'b1;
      end else begin
        hold_nxt = hold_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx         <= IDX_END;
      hold_q      <= '0;
      fully_muted <= 1'b1;
    end else begin
      idx         <= idx_nxt;
      hold_q      <= hold_nxt;
      fully_muted <= (idx_nxt == IDX_END);
    end
  end

  assert_idx_still_R10: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(idx));
  assert_mute_dir_R5: assert property (@(posedge clk) disable iff (rst)
    (step_en && eff_mute) |=> (idx == $past(idx) || idx == $past(idx) + 1'b1));
  assert_release_dir_R6: assert property (@(posedge clk) disable iff (rst)
    (step_en && !eff_mute) |=> (idx == $past(idx) || idx == $past(idx) - 1'b1));
  assert_idx_range_R5: assert property (@(posedge clk) disable iff (rst)
    idx <= IDX_END);
  assert_flag_track_R11: assert property (@(posedge clk) disable iff (rst)
    fully_muted == (idx == IDX_END));

endmodule

// File: rtl/smr_coef_rom.sv
module smr_coef_rom
  import smr_pkg::*;
(
  input  logic              clk,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  output logic [COEF_W-1:0] coef_q,
  output logic              unity_q,
  output logic              zero_q
);

  // registered read so the table maps onto a synchronous ROM
  always_ff @(posedge clk) begin
    if (rd_en) begin
      coef_q  <= ramp_coef(idx[4:0]);
      unity_q <= (idx == '0);
      zero_q  <= (idx == IDX_W'(STEPS));
    end
  end

endmodule

// File: rtl/smr_scaler.sv
module smr_scaler
  import smr_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] sample,
  input  logic [COEF_W-1:0]        coef,
  input  logic                     unity,
  input  logic                     zero,
  output logic signed [DATA_W-1:0] result
);

  localparam int PW = DATA_W + COEF_W + 1;
  localparam logic signed [DATA_W-1:0] SMAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] SMIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [PW-1:0]     a_ext, c_ext, prod, rsum;
  logic signed [DATA_W:0]   shifted;
  logic signed [DATA_W-1:0] sat;

  always_comb begin
    a_ext   = PW'(sample);
    c_ext   = PW'({1'b0, coef});
    prod    = a_ext * c_ext;
    rsum    = prod + (PW'(1) <<< (COEF_W - 1));
    shifted = rsum[PW-1:COEF_W];
    if (shifted[DATA_W] != shifted[DATA_W-1])
      sat = shifted[DATA_W] ? SMIN : SMAX;
    else
      sat = shifted[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
    end else if (in_valid) begin
      if (zero)       result <= '0;
      else if (unity) result <= sample;
      else            result <= sat;
    end
  end

  assert_unity_pass_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && unity) |=> result == $past(sample));
  assert_zero_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && zero) |=> result == '0);

endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp
  import smr_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int HOLD_LEN = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_valid,
  input  logic signed [DATA_W-1:0] smp_left,
  input  logic signed [DATA_W-1:0] smp_right,
  input  logic                     mute_req,
  input  logic                     pll_locked,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_left,
  output logic signed [DATA_W-1:0] out_right,
  output logic                     fully_muted
);

  logic [IDX_W-1:0]  gain_idx;
  logic [COEF_W-1:0] coef_q;
  logic              unity_q, zero_q;
  logic              s1_valid;
  logic signed [DATA_W-1:0] s1_smp [2];
  logic signed [DATA_W-1:0] res    [2];

  smr_ramp_ctrl #(.HOLD_LEN(HOLD_LEN)) u_ctrl (
    .clk(clk), .rst(rst), .step_en(smp_valid), .mute_req(mute_req),
    .pll_locked(pll_locked), .idx(gain_idx), .fully_muted(fully_muted)
  );

  smr_coef_rom u_rom (
    .clk(clk), .rd_en(smp_valid), .idx(gain_idx),
    .coef_q(coef_q), .unity_q(unity_q), .zero_q(zero_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      out_valid <= 1'b0;
      s1_smp[0] <= '0;
      s1_smp[1] <= '0;
    end else begin
      s1_valid  <= smp_valid;
      out_valid <= s1_valid;
      if (smp_valid) begin
        s1_smp[0] <= smp_left;
        s1_smp[1] <= smp_right;
      end
    end
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    smr_scaler #(.DATA_W(DATA_W)) u_scale (
      .clk(clk), .rst(rst), .in_valid(s1_valid), .sample(s1_smp[ch]),
      .coef(coef_q), .unity(unity_q), .zero(zero_q), .result(res[ch])
    );
  end

  assign out_left  = res[0];
  assign out_right = res[1];

  assert_latency_fwd_R2: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> ##2 out_valid);
  assert_latency_bwd_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(smp_valid, 2));

endmodule

// File: tb/soft_mute_ramp_test.sv
module soft_mute_ramp_test;

  localparam int DW   = 24;
  localparam int HOLD = 32;
  localparam real PI  = 3.14159265358979;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic signed [DW-1:0] smp_left = '0, smp_right = '0;
  logic mute_req = 1'b0, pll_locked = 1'b0;
  logic out_valid, fully_muted;
  logic signed [DW-1:0] out_left, out_right;

  int n_checks = 0, n_fails = 0;
  int m_idx = 32, m_hold = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  soft_mute_ramp #(.DATA_W(DW), .HOLD_LEN(HOLD)) uut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_left(smp_left),
    .smp_right(smp_right), .mute_req(mute_req), .pll_locked(pll_locked),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
    .fully_muted(fully_muted)
  );

  task automatic check(input string req, input int act, input int exp, input int tol);
    int d;
    n_checks++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_out(input int x, input int k);
    real c;
    if (k == 0) return x;
    if (k >= 32) return 0;
    c = 0.5 * (1.0 + $cos(PI * k / 32.0));
    return $rtoi($floor(x * c + 0.5));
  endfunction

  function automatic int tol_of(input int x, input int k);
    if (k == 0 || k >= 32) return 0;
    return ((x < 0 ? -x : x) >>> 15) + 1;
  endfunction

  // gain position rules of R5, R6, R7, R8
  task automatic model_step();
    bit eff;
    bit mv;
    eff = mute_req | !pll_locked;
    mv  = eff ? (m_idx != 32) : (m_idx != 0);
    if (mv) begin
      if (m_hold == HOLD - 1) begin
        m_hold = 0;
        m_idx  = eff ? m_idx + 1 : m_idx - 1;
      end else begin
        m_hold++;
      end
    end
  endtask

  task automatic send(input int xl, input int xr, input string req);
    int k, el, er;
    @(negedge clk);
    smp_valid = 1'b1;
    smp_left  = DW'(xl);
    smp_right = DW'(xr);
    k  = m_idx;
    el = expect_out(xl, k);
    er = expect_out(xr, k);
    model_step();
    @(negedge clk);
    smp_valid = 1'b0;
    check("R2 no early valid", int'(out_valid), 0, 0);
    @(negedge clk);
    check("R2 valid", int'(out_valid), 1, 0);
    check({req, " R9 left"},  int'(out_left),  el, tol_of(xl, k));
    check({req, " R9 right"}, int'(out_right), er, tol_of(xr, k));
    check("R11 flag", int'(fully_muted), (m_idx == 32) ? 1 : 0, 0);
    @(negedge clk);
    check("R2 single pulse", int'(out_valid), 0, 0);
  endtask

  function automatic int rnd_sample();
    return int'($urandom % (1 << DW)) - (1 << (DW - 1));
  endfunction

  task automatic run(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      int a, b;
      a = rnd_sample();
      b = rnd_sample();
      if (i % 11 == 3) begin a = (1 << (DW - 1)) - 1; b = -(1 << (DW - 1)); end
      if (i % 13 == 5) begin a = -(1 << (DW - 1)); b = 1; end
      send(a, b, req);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 fully_muted", int'(fully_muted), 1, 0);
    check("R1 out_valid", int'(out_valid), 0, 0);
    check("R1 out_left", int'(out_left), 0, 0);
    check("R1 out_right", int'(out_right), 0, 0);

    // R8 forced mute while unlocked, R4 zero output
    mute_req = 1'b0; pll_locked = 1'b0;
    run(40, "R8 R4 unlocked");
    // R6 fade in after lock, R3 unity once settled
    pll_locked = 1'b1;
    run(1100, "R6 R3 lock fade in");
    // R7 reversal mid-ramp
    mute_req = 1'b1;
    run(500, "R5 partial mute");
    mute_req = 1'b0;
    run(300, "R7 reverse up");
    // R5 full fade out, R4 silence
    mute_req = 1'b1;
    run(1200, "R5 R4 full mute");
    mute_req = 1'b0;
    run(1100, "R6 R3 release");
    // R8 lock loss overrides an unmuted request
    pll_locked = 1'b0;
    run(100, "R8 lock loss");
    pll_locked = 1'b1;
    run(200, "R8 R7 relock");
    // R10 idle cycles do not advance the ramp
    repeat (50) @(negedge clk);
    run(40, "R10 after idle");
    finish_run();
  end

endmodule